// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an I2C host read and write a byte-wide register file. It runs on a system clock many times faster than SCL. Both bus lines pass through synchronizers, and the bus events are recovered from the synchronized levels. The target recognises START, repeated START and STOP. It answers one 7-bit device address, whose least significant bit is taken from a strap input. SDA is driven open-drain: the `sdaOe` output means "pull SDA low".

A write transaction carries the device address with the R/W bit clear, then a register pointer, then any number of data bytes. Each data byte goes to the register at the current pointer, and the pointer then steps by one. A read first sets the pointer in the same way. The host then issues a repeated START and the address with R/W set. The target then returns consecutive registers, most significant bit first, for as long as the host acknowledges. The register file connects through a combinational read port addressed by the pointer and a single-cycle write strobe.

Top module: `i2cRegTarget`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0x16 with `addrStrap` low, or 0x17 with `addrStrap` high. The bit following the address is R/W, with 0 meaning write.
- R2: An address byte with any other value gets no acknowledge. `sdaOe` stays low until the next START.
- R3: The first byte after a write address is acknowledged and becomes the register pointer.
- R4: Every later write byte is acknowledged. It produces exactly one `regWe` pulse, with `regAddr` equal to the pointer and `regWdata` equal to the byte, and the pointer then advances by one.
- R5: After a repeated START with a read address, the target sends the register at the pointer MSB first. It continues with pointer+1, pointer+2 and so on while the host acknowledges each byte (SDA low in the ninth clock).
- R6: The pointer wraps from 0xFF to 0x00, for both writes and reads.
- R7: When the host does not acknowledge a read byte (SDA high in the ninth clock), the target stops driving SDA until the next START.
- R8: A STOP returns the target to idle. Bytes clocked after it without a new START get no acknowledge and cause no write.
- R9: While `rstN` is low, `sdaOe` and `regWe` are low from the next clock edge on.
- R10: `regWe` is never high on two consecutive cycles.
- R11: `sdaOe` changes only while SCL is low, so the target never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addrStrap | input | 1 | Selects the LSB of the device address |
| regWe | output | 1 | Single-cycle register write strobe |
| regAddr | output | DATA_W | Register pointer, used for both write and read |
| regWdata | output | DATA_W | Data written with `regWe` |
| regRdata | input | DATA_W | Combinational read data for `regAddr` |

## Verification
Some properties are checked on every cycle:
- The write strobe is a single-cycle pulse.
- Each write advances the pointer by one, wrapping at the top.
- Each write is followed by an acknowledge.
- `sdaOe` never changes while SCL is high.
- The target is quiet during reset.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole byte sequences on the bus:
- address matching against the strap, and the silence that follows a mismatch;
- pointer loading and read-back order across the wrap;
- the effect of a host NACK;
- bytes clocked after a STOP without a new START.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  // Strobes issued by the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;   // sample SDA into the shift register
    logic shiftOut;  // move next transmit bit to the MSB
    logic loadTx;    // load read data from the register file
    logic cntClr;    // clear the bit counter
    logic cntInc;    // count one SCL rising edge
    logic ptrLoad;   // pointer takes the received byte
    logic ptrInc;    // pointer steps by one
    logic wrEn;      // register file write strobe
  } tgtStrobe_t;

  typedef enum logic [1:0] {
    DRV_OFF,
    DRV_ACK,
    DRV_TX
  } drvMode_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_HACK
  } tgtState_t;

endpackage

// File: rtl/i2cTgtSync.sv
module i2cTgtSync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= RST_VAL;
        else       pipe[0] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[i] <= RST_VAL;
        else       pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dOut = pipe[STAGES-1];
endmodule

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  tgtStrobe_t        strb,
  input  drvMode_t          drvMode,
  input  logic [DATA_W-1:0] regRdata,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              byteDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaOe,
  output logic              regWe,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(DATA_W);

  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] ptr;
  logic              oeQ;

  i2cTgtSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .dIn(sclIn), .dOut(sclS)
  );
  i2cTgtSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .dIn(sdaIn), .dOut(sdaS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // Bus events from synchronized levels
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign byteDone  = (bitCnt == BITS_PER_BYTE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.cntClr) begin
      bitCnt <= '0;
    end else if (strb.cntInc) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.loadTx) begin
      shReg <= regRdata;
    end else if (strb.shiftOut) begin
      shReg <= {shReg[DATA_W-2:0], 1'b1};
    end else if (strb.shiftIn) begin
      shReg <= {shReg[DATA_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= shReg;
    end else if (strb.ptrInc) begin
      ptr <= ptr + 1'b1;
    end
  end

  // Registered open-drain enable keeps the pad free of glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeQ <= 1'b0;
    end else begin
      oeQ <= (drvMode == DRV_ACK) | ((drvMode == DRV_TX) & ~shReg[DATA_W-1]);
    end
  end

  assign sdaOe    = oeQ;
  assign rxByte   = shReg;
  assign regWe    = strb.wrEn;
  assign regAddr  = ptr;
  assign regWdata = shReg;
endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter int                    DATA_W     = 8,
  parameter int                    DEV_ADDR_W = 7,
  parameter logic [DEV_ADDR_W-1:0] BASE_ADDR  = 7'h16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrap,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  output tgtStrobe_t        strb,
  output drvMode_t          drvMode
);
  tgtState_t state, stateNxt;
  logic      rwQ, rwNxt;
  logic      addrHit;

  assign addrHit = (rxByte[DATA_W-1 -: DEV_ADDR_W] ==
                    {BASE_ADDR[DEV_ADDR_W-1:1], addrStrap});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rwQ   <= 1'b0;
    end else begin
      state <= stateNxt;
      rwQ   <= rwNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    rwNxt    = rwQ;
    if (stopSeen) begin
      stateNxt = ST_IDLE;
    end else if (startSeen) begin
      stateNxt    = ST_ADDR;
      strb.cntClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            strb.cntInc  = 1'b1;
          end
          if (sclFall && byteDone) begin
            strb.cntClr = 1'b1;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                rwNxt    = rxByte[0];
                stateNxt = ST_ADDR_ACK;
              end else begin
                stateNxt = ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              strb.ptrLoad = 1'b1;
              stateNxt     = ST_PTR_ACK;
            end else begin
              strb.wrEn   = 1'b1;
              strb.ptrInc = 1'b1;
              stateNxt    = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rwQ) begin
              strb.loadTx = 1'b1;
              strb.ptrInc = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (sclFall) stateNxt = ST_WDATA;
        end
        ST_TX: begin
          if (sclRise) strb.cntInc = 1'b1;
          if (sclFall) begin
            if (byteDone) begin
              strb.cntClr = 1'b1;
              stateNxt    = ST_HACK;
            end else begin
              strb.shiftOut = 1'b1;
            end
          end
        end
        ST_HACK: begin
          if (sclRise) strb.shiftIn = 1'b1;
          if (sclFall) begin
            if (!rxByte[0]) begin
              strb.loadTx = 1'b1;
              strb.ptrInc = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: drvMode = DRV_ACK;
      ST_TX:                                 drvMode = DRV_TX;
      default:                               drvMode = DRV_OFF;
    endcase
  end
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter int                    DATA_W      = 8,
  parameter int                    DEV_ADDR_W  = 7,
  parameter logic [DEV_ADDR_W-1:0] BASE_ADDR   = 7'h16,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              addrStrap,
  output logic              regWe,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  tgtStrobe_t        strb;
  drvMode_t          drvMode;
  logic              sclRise, sclFall, startSeen, stopSeen, byteDone;
  logic [DATA_W-1:0] rxByte;

  i2cTgtCtrl #(
    .DATA_W(DATA_W), .DEV_ADDR_W(DEV_ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .byteDone(byteDone), .rxByte(rxByte),
    .strb(strb), .drvMode(drvMode)
  );

  i2cTgtData #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_data (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .drvMode(drvMode), .regRdata(regRdata),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .byteDone(byteDone), .rxByte(rxByte), .sdaOe(sdaOe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata)
  );
endmodule

// File: rtl/i2cTgtChecker.sv
module i2cTgtChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              regWe,
  input logic [DATA_W-1:0] regAddr
);
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!sdaOe && !regWe));

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (regAddr == DATA_W'($past(regAddr) + 1'b1)));

  // R4
  write_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> ##1 sdaOe);

  // R11
  scl_low_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);
endmodule

bind i2cRegTarget i2cTgtChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regWe(regWe), .regAddr(regAddr)
);

// File: tb/test_i2cRegTarget.sv
module test_i2cRegTarget;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       addrStrap = 1'b0;
  logic       sdaIn, sdaOe, regWe;
  logic [7:0] regAddr, regWdata, regRdata;

  logic [7:0]  regFile  [256];
  logic [7:0]  modelMem [256];
  logic [15:0] expWr [$];

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 0;
  bit  lastWe = 0;
  bit  quietWin = 0;
  int  quietHits = 0;
  int  sclHighChanges = 0;
  logic prevOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaIn    = sdaDrv & ~sdaOe;
  assign regRdata = regFile[regAddr];

  i2cRegTarget i_i2cRegTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .addrStrap(addrStrap), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always @(posedge clk) if (regWe) regFile[regAddr] <= regWdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write-port scoreboard, every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (regWe) begin
        check(!lastWe, "R10 strobe width", 2, 1);
        if (expWr.size() == 0) begin
          check(1'b0, "R4/R8 unexpected write", {regAddr, regWdata}, 0);
        end else begin
          logic [15:0] e;
          e = expWr.pop_front();
          check({regAddr, regWdata} == e, "R4 write addr/data", {regAddr, regWdata}, e);
        end
      end
      lastWe = regWe;
      if (quietWin && sdaOe) quietHits++;
      if (sdaOe != prevOe && sclIn) sclHighChanges++;
      prevOe = sdaOe;
    end
  end

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclIn  = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclIn  = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclIn  = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ(); waitQ();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    waitQ();
    sdaDrv = b; waitQ();
    sclIn = 1'b1; waitQ();
    seen = sdaIn; waitQ();
    sclIn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    check(s == !expAck, {tag, " ack bit"}, s, !expAck);
  endtask

  task automatic recvByte(input logic [7:0] exp, input bit hostAck, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      got[i] = s;
    end
    clockBit(!hostAck, s);
    check(got == exp, {tag, " read byte"}, got, exp);
  endtask

  function automatic logic [7:0] devByte(input bit rd);
    return {6'b001011, addrStrap, rd};
  endfunction

  task automatic doWrite(input logic [7:0] ptr, input logic [7:0] dq[$], input string tag);
    busStart();
    sendByte(devByte(0), 1, "R1 write address");
    sendByte(ptr, 1, "R3 pointer");
    foreach (dq[i]) begin
      logic [7:0] a;
      a = ptr + 8'(i);
      expWr.push_back({a, dq[i]});
      modelMem[a] = dq[i];
      sendByte(dq[i], 1, tag);
    end
    busStop();
  endtask

  task automatic doRead(input logic [7:0] ptr, input int n, input string tag);
    busStart();
    sendByte(devByte(0), 1, "R1 write address");
    sendByte(ptr, 1, "R3 pointer");
    busStart();
    sendByte(devByte(1), 1, "R1 read address");
    for (int i = 0; i < n; i++) recvByte(modelMem[8'(ptr + 8'(i))], i < n - 1, tag);
    busStop();
  endtask

  task automatic quietCheck(input string tag);
    check(quietHits == 0, tag, quietHits, 0);
    quietWin = 0;
    quietHits = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      regFile[i]  = 8'(i * 7 + 3);
      modelMem[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R9 sdaOe in reset", sdaOe, 0);
    check(regWe == 1'b0, "R9 regWe in reset", regWe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3 R4: write with strap low
    doWrite(8'h10, '{8'hA5, 8'h3C, 8'h7E}, "R4 data ack");
    // R5: read back across consecutive registers
    doRead(8'h10, 3, "R5");
    doRead(8'h12, 4, "R5 untouched regs");

    // R7: host NACK, then further clocks must see a released line
    busStart();
    sendByte(devByte(0), 1, "R1 write address");
    sendByte(8'h10, 1, "R3 pointer");
    busStart();
    sendByte(devByte(1), 1, "R1 read address");
    recvByte(modelMem[8'h10], 0, "R7 last byte");
    quietWin = 1;
    recvByte(8'hFF, 0, "R7 after NACK");
    quietCheck("R7 sdaOe after NACK");
    busStop();

    // R2: mismatched address with strap low
    busStart();
    quietWin = 1;
    sendByte(8'h2E, 0, "R2 foreign address");
    sendByte(8'h55, 0, "R2 ignored byte");
    quietCheck("R2 sdaOe after mismatch");
    busStop();

    // R1 R6: strap high, wrap the pointer on write and read
    addrStrap = 1'b1;
    repeat (5) @(negedge clk);
    doWrite(8'hFE, '{8'h11, 8'h22, 8'h33}, "R6 wrap write");
    doRead(8'hFE, 3, "R6 wrap read");

    // R2: low-strap address while strap high
    busStart();
    quietWin = 1;
    sendByte(8'h2C, 0, "R2 other strap address");
    quietCheck("R2 sdaOe other strap");
    busStop();

    // R8: bytes after STOP without START
    sclIn = 1'b0;
    waitQ();
    quietWin = 1;
    sendByte(8'h2E, 0, "R8 address without START");
    sendByte(8'h44, 0, "R8 data without START");
    quietCheck("R8 sdaOe after STOP");
    busStart();
    busStop();
    doRead(8'h00, 2, "R8 memory unchanged");

    repeat (20) @(negedge clk);
    check(expWr.size() == 0, "R4 pending writes", expWr.size(), 0);
    check(sclHighChanges == 0, "R11 sdaOe change with SCL high", sclHighChanges, 0);
    finish();
  end
endmodule